// File: doc/BRIEF.md
# Per-Channel Packet Length Guard

This block watches a packet stream in which up to 64 logical channels may be interleaved beat by beat. Each beat carries a channel number, start and end markers and the number of valid bytes in that beat. For each channel the block keeps a running byte total. It compares that total against a lower and an upper length bound that are programmed for that channel. When the total first rises above the upper bound it emits an oversize pulse at once. When the packet ends it reports whether the packet was short, long, or neither.

A simple register port reads and writes the bound table. The same port reads a per-channel count of flagged packets, and that count is cleared when it is read. What happens to a flagged packet afterwards is decided elsewhere.

Top module: `pkt_len_guard`

## Requirements
- R1: After reset every channel has a lower bound of 64 and an upper bound of 1518, so a limits read returns 0x05EE0040. All flagged-packet counts read 0, and ovr_pulse, done_valid and reg_rvalid are low.
- R2: A limits word has the lower bound in bits 7:0 and the upper bound in bits 29:16. It is addressed by reg_addr[6]=0 with reg_addr[5:0] as the channel. A write takes the two fields and ignores the other bits. A read presents reg_rvalid and reg_rdata one cycle after the request, and the unused bits read as zero.
- R3: At the end beat, done_valid rises one cycle later with done_chan set to the beat's channel. done_under is 1 exactly when the packet's byte total is below that channel's lower bound. A total equal to the lower bound is not short.
- R4: On the beat where a channel's running total first exceeds its upper bound, ovr_pulse is high for one cycle on the following cycle, with ovr_chan set to the beat's channel. A total equal to the upper bound does not trigger it. The check works up to the largest bound, 16383.
- R5: Within one packet ovr_pulse fires at most once. done_over at the end beat is 1 if the total went above the upper bound at any point in the packet.
- R6: Byte totals of interleaved packets on different channels are kept apart, and each is checked against its own channel's bounds.
- R7: Each packet that ends short or long adds one to its channel's count. The count is read with reg_addr[6]=1 and reg_addr[5:0] as the channel. The read returns the count in bits 15:0, with zero above, and sets the count to zero.
- R8: The per-channel count stops at 65535 and does not wrap.
- R9: A start beat begins a new total from that beat's bytes, discarding any unfinished total on that channel.
- R10: A write to a count address changes neither the count nor any bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 7 | Bit 6 selects count (1) or limits (0); bits 5:0 give the channel |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| reg_rdata | output | 32 | Read data |
| in_valid | input | 1 | Stream beat valid |
| in_chan | input | 6 | Channel of the beat |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_bytes | input | 5 | Valid bytes in the beat (0 to 16) |
| ovr_pulse | output | 1 | Oversize detected on the previous beat |
| ovr_chan | output | 6 | Channel of the oversize pulse |
| done_valid | output | 1 | Packet ended on the previous beat |
| done_chan | output | 6 | Channel of the ended packet |
| done_under | output | 1 | Ended packet was short |
| done_over | output | 1 | Ended packet was long |

## Verification
Two situations are hard to reach from the ports. The first is saturation of the flagged-packet count, which needs 65,535 short packets on one channel. The stimulus sends more than that many single-beat, zero-byte packets back to back, then reads the count twice, expecting the ceiling and then zero. The second is the exact upper bound of 16383. One channel's bound is set to it, and the bench sends one packet of exactly that length and one that is a single byte longer, so the pulse must appear only on the closing beat of the second. Interleaving and restart-without-end are produced by alternating channels beat by beat and by opening a new packet on a channel whose previous one never ended.

// File: rtl/pkt_len_guard_pkg.sv
// Package: shared sizing defaults for the packet length guard.
// Assumes: the limits word layout puts the lower bound at bit 0 and the
// upper bound at bit WORD_MAX_LSB of a WORD_W-bit register word.
package pkt_len_guard_pkg;
    localparam int unsigned DEF_CHANS   = 64;
    localparam int unsigned DEF_MIN_W   = 8;
    localparam int unsigned DEF_MAX_W   = 14;
    localparam int unsigned DEF_TOT_W   = 16;
    localparam int unsigned DEF_ERR_W   = 16;
    localparam int unsigned DEF_BEAT_W  = 5;
    localparam int unsigned WORD_W      = 32;
    localparam int unsigned WORD_MAX_LSB = 16;
    localparam int unsigned DEF_MIN_RST = 64;
    localparam int unsigned DEF_MAX_RST = 1518;
endpackage

// File: rtl/pkt_len_limits.sv
// Module: per-channel table of lower and upper length bounds.
// Holds one bound pair per channel in flops; one write port, two
// asynchronous read ports (register side and stream side).
// Assumes: writes are single-cycle strobes; reset loads the defaults.
module pkt_len_limits #(
    parameter int unsigned CHANS   = 64,
    parameter int unsigned CHAN_W  = 6,
    parameter int unsigned MIN_W   = 8,
    parameter int unsigned MAX_W   = 14,
    parameter int unsigned MIN_RST = 64,
    parameter int unsigned MAX_RST = 1518
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHAN_W-1:0] wr_idx,
    input  logic [MIN_W-1:0]  wr_min,
    input  logic [MAX_W-1:0]  wr_max,
    input  logic [CHAN_W-1:0] rd_idx,
    output logic [MIN_W-1:0]  rd_min,
    output logic [MAX_W-1:0]  rd_max,
    input  logic [CHAN_W-1:0] lk_idx,
    output logic [MIN_W-1:0]  lk_min,
    output logic [MAX_W-1:0]  lk_max
);
    logic [MIN_W-1:0] min_q [CHANS];
    logic [MAX_W-1:0] max_q [CHANS];

    // Table storage: reset to defaults, overwrite one entry per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CHANS; i++) begin
                min_q[i] <= MIN_W'(MIN_RST);
                max_q[i] <= MAX_W'(MAX_RST);
            end
        end else if (wr_en) begin
            min_q[wr_idx] <= wr_min;
            max_q[wr_idx] <= wr_max;
        end
    end

    // Read ports: plain indexed lookups.
    always_comb begin
        rd_min = min_q[rd_idx];
        rd_max = max_q[rd_idx];
        lk_min = min_q[lk_idx];
        lk_max = max_q[lk_idx];
    end
endmodule

// File: rtl/pkt_len_track.sv
// Module: per-channel running byte totals and length verdicts.
// Each beat updates its channel's saturating total; an oversize pulse is
// raised once per packet, and the verdict is produced at the end beat.
// All outputs are registered: they appear the cycle after the beat.
// Assumes: lim_min/lim_max are the bounds of in_chan in the same cycle.
module pkt_len_track #(
    parameter int unsigned CHANS  = 64,
    parameter int unsigned CHAN_W = 6,
    parameter int unsigned TOT_W  = 16,
    parameter int unsigned MIN_W  = 8,
    parameter int unsigned MAX_W  = 14,
    parameter int unsigned BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BEAT_W-1:0] in_bytes,
    input  logic [MIN_W-1:0]  lim_min,
    input  logic [MAX_W-1:0]  lim_max,
    output logic              ovr_pulse,
    output logic [CHAN_W-1:0] ovr_chan,
    output logic              done_valid,
    output logic [CHAN_W-1:0] done_chan,
    output logic              done_under,
    output logic              done_over
);
    logic [TOT_W-1:0] tot_q [CHANS];
    logic [CHANS-1:0] seen_q;
    logic [TOT_W-1:0] base;
    logic [TOT_W:0]   sum;
    logic [TOT_W-1:0] next_tot;
    logic             prev_over;
    logic             over_now;
    logic             under_now;

    // Next total for the addressed channel and the bound comparisons.
    always_comb begin
        base      = in_sop ? '0 : tot_q[in_chan];
        prev_over = !in_sop && seen_q[in_chan];
        sum       = {1'b0, base} + (TOT_W+1)'(in_bytes);
        next_tot  = sum[TOT_W] ? '1 : sum[TOT_W-1:0];
        over_now  = next_tot > TOT_W'(lim_max);
        under_now = next_tot < TOT_W'(lim_min);
    end

    // Per-channel state: total and "already oversize" bit, cleared at end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CHANS; i++) tot_q[i] <= '0;
            seen_q <= '0;
        end else if (in_valid) begin
            tot_q[in_chan]  <= in_eop ? '0 : next_tot;
            seen_q[in_chan] <= !in_eop && (over_now || prev_over);
        end
    end

    // Registered reporting of the pulse and the end-of-packet verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_pulse  <= 1'b0;
            ovr_chan   <= '0;
            done_valid <= 1'b0;
            done_chan  <= '0;
            done_under <= 1'b0;
            done_over  <= 1'b0;
        end else begin
            ovr_pulse  <= in_valid && over_now && !prev_over;
            ovr_chan   <= in_chan;
            done_valid <= in_valid && in_eop;
            done_chan  <= in_chan;
            done_under <= in_valid && in_eop && under_now;
            done_over  <= in_valid && in_eop && (over_now || prev_over);
        end
    end
endmodule

// File: rtl/pkt_len_errcnt.sv
// Module: per-channel saturating count of flagged packets, clear on read.
// A clear and an increment on the same channel in one cycle leave 1.
// Assumes: rd_val is sampled by the caller in the cycle clr_en is high.
module pkt_len_errcnt #(
    parameter int unsigned CHANS  = 64,
    parameter int unsigned CHAN_W = 6,
    parameter int unsigned ERR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [CHAN_W-1:0] inc_idx,
    input  logic              clr_en,
    input  logic [CHAN_W-1:0] clr_idx,
    input  logic [CHAN_W-1:0] rd_idx,
    output logic [ERR_W-1:0]  rd_val
);
    logic [ERR_W-1:0] cnt_q [CHANS];

    // Counter bank: clear on read wins, increment saturates at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CHANS; i++) cnt_q[i] <= '0;
        end else begin
            for (int i = 0; i < CHANS; i++) begin
                if (clr_en && clr_idx == CHAN_W'(i))
                    cnt_q[i] <= (inc_en && inc_idx == CHAN_W'(i)) ? ERR_W'(1) : '0;
                else if (inc_en && inc_idx == CHAN_W'(i) && cnt_q[i] != '1)
                    cnt_q[i] <= cnt_q[i] + ERR_W'(1);
            end
        end
    end

    // Read port: indexed lookup.
    assign rd_val = cnt_q[rd_idx];
endmodule

// File: rtl/pkt_len_guard.sv
// Module: top of the per-channel packet length guard.
// Decodes the register port (limits table or flagged-packet counts),
// registers read data with one cycle latency, and joins the bound table,
// the byte tracker and the counter bank.
// Assumes: the stream and register port share clk; no back-pressure.
module pkt_len_guard
    import pkt_len_guard_pkg::*;
#(
    parameter int unsigned CHANS   = DEF_CHANS,
    parameter int unsigned MIN_W   = DEF_MIN_W,
    parameter int unsigned MAX_W   = DEF_MAX_W,
    parameter int unsigned TOT_W   = DEF_TOT_W,
    parameter int unsigned ERR_W   = DEF_ERR_W,
    parameter int unsigned BEAT_W  = DEF_BEAT_W,
    parameter int unsigned MIN_RST = DEF_MIN_RST,
    parameter int unsigned MAX_RST = DEF_MAX_RST,
    localparam int unsigned CHAN_W = $clog2(CHANS),
    localparam int unsigned ADDR_W = CHAN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic              reg_rvalid,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              in_valid,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BEAT_W-1:0] in_bytes,
    output logic              ovr_pulse,
    output logic [CHAN_W-1:0] ovr_chan,
    output logic              done_valid,
    output logic [CHAN_W-1:0] done_chan,
    output logic              done_under,
    output logic              done_over
);
    logic              sel_cnt;
    logic              rd_req;
    logic              lim_wr;
    logic [CHAN_W-1:0] reg_idx;
    logic [MIN_W-1:0]  rd_min;
    logic [MAX_W-1:0]  rd_max;
    logic [MIN_W-1:0]  lk_min;
    logic [MAX_W-1:0]  lk_max;
    logic [ERR_W-1:0]  rd_err;
    logic [WORD_W-1:0] word_lim;
    logic [WORD_W-1:0] word_err;
    logic              unused_wbits;

    // Register port decode.
    always_comb begin
        sel_cnt = reg_addr[CHAN_W];
        reg_idx = reg_addr[CHAN_W-1:0];
        rd_req  = reg_req && !reg_wr;
        lim_wr  = reg_req && reg_wr && !sel_cnt;
    end

    assign unused_wbits = ^{reg_wdata[WORD_W-1:WORD_MAX_LSB+MAX_W],
                            reg_wdata[WORD_MAX_LSB-1:MIN_W]};

    pkt_len_limits #(
        .CHANS(CHANS), .CHAN_W(CHAN_W), .MIN_W(MIN_W), .MAX_W(MAX_W),
        .MIN_RST(MIN_RST), .MAX_RST(MAX_RST)
    ) limits_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lim_wr), .wr_idx(reg_idx),
        .wr_min(reg_wdata[MIN_W-1:0]),
        .wr_max(reg_wdata[WORD_MAX_LSB +: MAX_W]),
        .rd_idx(reg_idx), .rd_min(rd_min), .rd_max(rd_max),
        .lk_idx(in_chan), .lk_min(lk_min), .lk_max(lk_max)
    );

    pkt_len_track #(
        .CHANS(CHANS), .CHAN_W(CHAN_W), .TOT_W(TOT_W),
        .MIN_W(MIN_W), .MAX_W(MAX_W), .BEAT_W(BEAT_W)
    ) track_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_chan(in_chan), .in_sop(in_sop),
        .in_eop(in_eop), .in_bytes(in_bytes),
        .lim_min(lk_min), .lim_max(lk_max),
        .ovr_pulse(ovr_pulse), .ovr_chan(ovr_chan),
        .done_valid(done_valid), .done_chan(done_chan),
        .done_under(done_under), .done_over(done_over)
    );

    pkt_len_errcnt #(
        .CHANS(CHANS), .CHAN_W(CHAN_W), .ERR_W(ERR_W)
    ) errcnt_i (
        .clk(clk), .rst_n(rst_n),
        .inc_en(done_valid && (done_under || done_over)),
        .inc_idx(done_chan),
        .clr_en(rd_req && sel_cnt), .clr_idx(reg_idx),
        .rd_idx(reg_idx), .rd_val(rd_err)
    );

    // Read word assembly: fields placed, unused bits zero.
    always_comb begin
        word_lim = '0;
        word_lim[MIN_W-1:0] = rd_min;
        word_lim[WORD_MAX_LSB +: MAX_W] = rd_max;
        word_err = '0;
        word_err[ERR_W-1:0] = rd_err;
    end

    // Read data register: one cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= rd_req;
            if (rd_req) reg_rdata <= sel_cnt ? word_err : word_lim;
        end
    end
endmodule

// File: rtl/pkt_len_guard_chk.sv
// Module: assertion checker for pkt_len_guard, attached by bind.
// Keeps a shadow bit per channel of "oversize already reported in the
// open packet" built only from port activity.
// Assumes: default word layout (lower bound at 0, upper bound at 16).
module pkt_len_guard_chk #(
    parameter int unsigned CHANS  = 64,
    parameter int unsigned CHAN_W = 6,
    parameter int unsigned MIN_W  = 8,
    parameter int unsigned MAX_W  = 14,
    parameter int unsigned ERR_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_wr,
    input logic [CHAN_W:0]   reg_addr,
    input logic              reg_rvalid,
    input logic [31:0]       reg_rdata,
    input logic              in_valid,
    input logic [CHAN_W-1:0] in_chan,
    input logic              in_sop,
    input logic              ovr_pulse,
    input logic [CHAN_W-1:0] ovr_chan,
    input logic              done_valid,
    input logic [CHAN_W-1:0] done_chan
);
    localparam logic [31:0] LIM_MASK = ((32'd1 << MIN_W) - 32'd1) |
                                       (((32'd1 << MAX_W) - 32'd1) << 16);
    localparam logic [31:0] ERR_MASK = (32'd1 << ERR_W) - 32'd1;

    logic [CHANS-1:0]  hit_q;
    logic [CHANS-1:0]  hit_d;
    logic              sop_d;
    logic [CHAN_W-1:0] sop_ch_d;

    // Shadow update: a start clears, a pulse sets, an end clears.
    always_comb begin
        hit_d = hit_q;
        if (sop_d) hit_d[sop_ch_d] = 1'b0;
        if (ovr_pulse) hit_d[ovr_chan] = 1'b1;
        if (done_valid) hit_d[done_chan] = 1'b0;
    end

    // Shadow state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= '0;
            sop_d    <= 1'b0;
            sop_ch_d <= '0;
        end else begin
            hit_q    <= hit_d;
            sop_d    <= in_valid && in_sop;
            sop_ch_d <= in_chan;
        end
    end

    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_wr) |=> reg_rvalid);
    assert_rvalid_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_req && !reg_wr));
    assert_lim_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rvalid && !$past(reg_addr[CHAN_W])) |-> ((reg_rdata & ~LIM_MASK) == 32'd0));
    assert_cnt_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rvalid && $past(reg_addr[CHAN_W])) |-> ((reg_rdata & ~ERR_MASK) == 32'd0));
    assert_done_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(in_valid) && done_chan == $past(in_chan));
    assert_pulse_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(in_valid) && ovr_chan == $past(in_chan));
    assert_pulse_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> !(hit_q[ovr_chan] && !(sop_d && sop_ch_d == ovr_chan)));
endmodule

bind pkt_len_guard pkt_len_guard_chk #(
    .CHANS(CHANS), .CHAN_W(CHAN_W), .MIN_W(MIN_W), .MAX_W(MAX_W), .ERR_W(ERR_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_chan(in_chan), .in_sop(in_sop),
    .ovr_pulse(ovr_pulse), .ovr_chan(ovr_chan),
    .done_valid(done_valid), .done_chan(done_chan)
);

// File: tb/pkt_len_guard_tb_top.sv
// Bench: scoreboard for pkt_len_guard. The beat driver keeps a model of
// per-channel totals, bounds and counts, and queues the expected stream
// events; a monitor pops and compares them as the design reports.
module pkt_len_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_wr = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [5:0]  in_chan = '0;
    logic [4:0]  in_bytes = '0;
    logic        ovr_pulse, done_valid, done_under, done_over;
    logic [5:0]  ovr_chan, done_chan;

    always #4 clk = ~clk;

    pkt_len_guard dut_i (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .in_valid(in_valid), .in_chan(in_chan),
        .in_sop(in_sop), .in_eop(in_eop), .in_bytes(in_bytes),
        .ovr_pulse(ovr_pulse), .ovr_chan(ovr_chan), .done_valid(done_valid),
        .done_chan(done_chan), .done_under(done_under), .done_over(done_over)
    );

    typedef struct {
        bit    pulse;
        bit    done;
        int    ch;
        bit    under;
        bit    over;
        string tag;
    } exp_t;

    exp_t  expq[$];
    int    n_vec = 0, n_bad = 0;
    int    mmin[64], mmax[64], mtot[64], merr[64];
    bit    mseen[64];
    bit    finished = 1'b0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each reported stream event with the queue head.
    always @(negedge clk) begin
        if (rst_n && (ovr_pulse || done_valid)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R3", "unexpected stream event", {ovr_pulse, done_valid}, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(ovr_pulse == e.pulse && done_valid == e.done, e.tag,
                      "event kind", {ovr_pulse, done_valid}, {e.pulse, e.done});
                if (e.pulse)
                    check(ovr_chan == 6'(e.ch), e.tag, "ovr_chan", ovr_chan, e.ch);
                if (e.done)
                    check(done_chan == 6'(e.ch) && done_under == e.under &&
                          done_over == e.over, e.tag, "done chan/under/over",
                          {done_chan, done_under, done_over}, {6'(e.ch), e.under, e.over});
            end
        end
    end

    // One stream beat; updates the model and queues the expected event.
    task automatic beat(int ch, bit sop, bit eop, int nb, string tag);
        int n;
        bit prev, ov, un;
        n    = (sop ? 0 : mtot[ch]) + nb;
        if (n > 65535) n = 65535;
        prev = sop ? 1'b0 : mseen[ch];
        ov   = n > mmax[ch];
        un   = n < mmin[ch];
        if ((ov && !prev) || eop) begin
            exp_t e;
            e.pulse = ov && !prev; e.done = eop; e.ch = ch;
            e.under = eop && un; e.over = eop && (ov || prev); e.tag = tag;
            expq.push_back(e);
        end
        if (eop) begin
            if ((un || ov || prev) && merr[ch] < 65535) merr[ch]++;
            mtot[ch] = 0; mseen[ch] = 1'b0;
        end else begin
            mtot[ch] = n; mseen[ch] = ov || prev;
        end
        in_valid = 1'b1; in_chan = 6'(ch); in_sop = sop; in_eop = eop; in_bytes = 5'(nb);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [6:0] a, logic [31:0] d);
        reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (!a[6]) begin mmin[a[5:0]] = int'(d[7:0]); mmax[a[5:0]] = int'(d[29:16]); end
        @(negedge clk);
        reg_req = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [6:0] a, logic [31:0] exp, string tag);
        reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_req = 1'b0;
        check(reg_rvalid && reg_rdata == exp, tag, "register read",
              {reg_rvalid, reg_rdata}, {1'b1, exp});
    endtask

    task automatic read_lim(int ch, string tag);
        reg_read(7'(ch), {2'b00, 14'(mmax[ch]), 8'h00, 8'(mmin[ch])}, tag);
    endtask

    task automatic read_cnt(int ch, string tag);
        idle(2);
        reg_read(7'(64 + ch), {16'h0, 16'(merr[ch])}, tag);
        merr[ch] = 0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mmin[i] = 64; mmax[i] = 1518; mtot[i] = 0; merr[i] = 0; mseen[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!ovr_pulse && !done_valid && !reg_rvalid, "R1", "outputs idle",
              {ovr_pulse, done_valid, reg_rvalid}, 0);
        reg_read(7'd0, 32'h05EE_0040, "R1");
        reg_read(7'd63, 32'h05EE_0040, "R1");
        read_cnt(0, "R1");

        // R2: write with reserved bits set; they must not appear
        reg_write(7'd1, 32'hC014_FF0A);
        reg_read(7'd1, 32'h0014_000A, "R2");

        // R3: exactly the lower bound is fine, one byte less is short
        beat(1, 1, 0, 4, "R3"); beat(1, 0, 1, 6, "R3");
        beat(1, 1, 0, 4, "R3"); beat(1, 0, 1, 5, "R3");
        // R4: exactly the upper bound is fine, one more pulses at once
        beat(1, 1, 0, 16, "R4"); beat(1, 0, 1, 4, "R4");
        beat(1, 1, 0, 16, "R4"); beat(1, 0, 1, 5, "R4");
        // R5: pulse on third beat only, end reports over
        beat(1, 1, 0, 8, "R5"); beat(1, 0, 0, 8, "R5");
        beat(1, 0, 0, 8, "R5"); beat(1, 0, 1, 8, "R5");

        // R6: interleaved channels 1 and 2 with different bounds
        beat(2, 1, 0, 8, "R6"); beat(1, 1, 0, 8, "R6");
        beat(2, 0, 0, 16, "R6"); beat(1, 0, 1, 4, "R6");
        beat(2, 0, 0, 16, "R6"); beat(2, 0, 1, 16, "R6");
        beat(2, 1, 0, 16, "R6"); beat(1, 1, 1, 16, "R6");
        beat(2, 0, 0, 16, "R6"); beat(2, 0, 0, 16, "R6");
        beat(2, 0, 1, 16, "R6");

        // R9: restart without an end discards the old total
        beat(1, 1, 0, 8, "R9"); beat(1, 0, 0, 8, "R9");
        beat(1, 1, 0, 8, "R9"); beat(1, 0, 1, 4, "R9");

        // R7: counts read and clear
        read_cnt(1, "R7");
        read_cnt(1, "R7");
        read_cnt(2, "R7");

        // R10: a write to a count address changes nothing
        beat(1, 1, 1, 3, "R10");
        idle(2);
        reg_write(7'(64 + 1), 32'h0000_1234);
        read_cnt(1, "R10");
        read_lim(1, "R10");

        // R4: largest upper bound, no lower bound
        reg_write(7'd3, 32'h3FFF_0000);
        read_lim(3, "R2");
        beat(3, 1, 0, 16, "R4");
        for (int k = 0; k < 1022; k++) beat(3, 0, 0, 16, "R4");
        beat(3, 0, 1, 15, "R4");
        beat(3, 1, 0, 16, "R4");
        for (int k = 0; k < 1022; k++) beat(3, 0, 0, 16, "R4");
        beat(3, 0, 1, 16, "R4");
        read_cnt(3, "R4");

        // R8: counter saturation with single-beat empty packets
        for (int k = 0; k < 65537; k++) beat(5, 1, 1, 0, "R8");
        read_cnt(5, "R8");
        read_cnt(5, "R8");

        idle(3);
        check(expq.size() == 0, "R3", "events left pending", expq.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule